// File: doc/BRIEF.md
# Fixed-Count Serial Byte Transceiver

This block sends and receives single bytes over a pair of serial lines. A frame is one low start bit, eight data bits with the least significant bit first, and one high stop bit. Each bit lasts a whole number of module clock cycles. That number comes from a 16-bit bit-period register that software writes and reads back.

The block never measures the incoming rate and never re-aligns to edges inside a frame. The receiver finds the falling edge of a start bit and checks the line again half a bit period later. After that it samples once per full period. So both ends need accurate clocks. The bit-period register keeps only even counts, which puts the real bit period within one clock of the ideal value. For example, an ideal period of about 21.33 clocks can be programmed as 22, which is about 0.67 clocks long. A write of 21 is stored as 20, which is about 1.33 clocks short.

Each direction copies the bit period when its frame starts. A register write during a frame therefore takes effect from the next frame.

Top module: `ubt_uart`

## Requirements
- R1: After synchronous reset, `cfg_rdata` reads the reset period (default 16), `txd` is high, `tx_busy` is low and `rx_valid` is low.
- R2: A write stores the written value with bit 0 forced to zero, so an odd value becomes the next lower even value: 21 reads back as 20, 22 as 22 and 0xFFFF as 0xFFFE. A read returns the stored value one cycle after the write.
- R3: After an accepted start, `txd` carries the start bit (0), `tx_data` bits 0 through 7 in that order, and then the stop bit (1). Each bit lasts exactly the stored period. The start bit begins in the cycle after the strobe.
- R4: `tx_busy` goes high in the cycle after an accepted start and stays high for 10 bit periods. It then drops, and `txd` is high whenever `tx_busy` is low.
- R5: A start strobe given while `tx_busy` is high is ignored. The current frame goes out unchanged and no second frame follows it.
- R6: A received frame raises `rx_valid` for exactly one cycle. At that moment `rx_data` holds the eight data bits, with the first bit after the start bit in bit 0.
- R7: If the stop bit is sampled low, `rx_frame_err` is high in the same cycle as the `rx_valid` pulse. Otherwise it is low, and it is never high without `rx_valid`.
- R8: If the line is high again when it is checked half a period after a falling edge, nothing is received, and the receiver waits for the next falling edge.
- R9: Each direction keeps the period it had at the start of its frame. A register write during a frame does not change the frame already in progress.
- R10: The transmitter and the receiver work independently. A frame can go out while another one comes in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the bit-period register |
| cfg_wdata | input | 16 | Bit period to write, in clock cycles |
| cfg_rdata | output | 16 | Stored bit period (always even) |
| tx_start | input | 1 | Starts a transmit frame when not busy |
| tx_data | input | 8 | Byte to transmit, sampled with `tx_start` |
| tx_busy | output | 1 | High while a frame is being sent |
| txd | output | 1 | Serial output, high when idle |
| rxd | input | 1 | Serial input |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle pulse when a byte has been received |
| rx_frame_err | output | 1 | Stop bit was low; valid with `rx_valid` |

## Verification
Two things can happen in the same cycles: a transmit frame going out and a receive frame being sampled. A register write can also land in the middle of both frames. The bench sends a transmit frame and drives a receive frame in parallel, starting them at the same edge, and rewrites the bit period during the transmit frame. It passes only if the sent bits keep the original period all the way to the stop bit, and if the received byte arrives correct with no framing error, even though the register now holds a different count.

// File: rtl/ubt_pkg.sv
package ubt_pkg;

    localparam int BYTE_W      = 8;
    localparam int FRAME_BITS  = BYTE_W + 2;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              frame_err;
    } rx_result_t;

    function automatic logic [31:0] even_floor(input logic [31:0] v);
        return {v[31:1], 1'b0};
    endfunction

endpackage

// File: rtl/ubt_bitreg.sv
module ubt_bitreg #(
    parameter int CNT_W     = 16,
    parameter int RESET_VAL = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] rdata
);
    import ubt_pkg::*;

    localparam logic [31:0] RESET_EVEN = even_floor(32'(RESET_VAL));

    logic [CNT_W-1:1] stored_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stored_q <= RESET_EVEN[CNT_W-1:1];
        end else if (we) begin
            stored_q <= wdata[CNT_W-1:1];
        end
    end

    assign rdata = {stored_q, 1'b0};

    // R2: the value read back is the written value with bit 0 cleared
    assert_even_store_R2: assert property (@(posedge clk) disable iff (rst)
        we |=> rdata == {$past(wdata[CNT_W-1:1]), 1'b0});

endmodule

// File: rtl/ubt_tx.sv
module ubt_tx #(
    parameter int CNT_W = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [CNT_W-1:0]          bit_time,
    input  logic                      start,
    input  logic [ubt_pkg::BYTE_W-1:0] data,
    output logic                      busy,
    output logic                      txd
);
    import ubt_pkg::*;

    localparam int LEFT_W = $clog2(FRAME_BITS);

    logic [CNT_W-1:0]  bt_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W:0]   shreg_q;
    logic [LEFT_W-1:0] left_q;
    logic              busy_q;
    logic              txd_q;
    logic              bit_end;

    assign bit_end = (cnt_q == bt_q - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            bt_q    <= '0;
            cnt_q   <= '0;
            shreg_q <= '1;
            left_q  <= '0;
            busy_q  <= 1'b0;
            txd_q   <= 1'b1;
        end else if (!busy_q) begin
            if (start) begin
                bt_q    <= bit_time;
                cnt_q   <= '0;
                shreg_q <= {1'b1, data};
                left_q  <= LEFT_W'(FRAME_BITS - 1);
                busy_q  <= 1'b1;
                txd_q   <= 1'b0;
            end
        end else if (bit_end) begin
            cnt_q <= '0;
            if (left_q == '0) begin
                busy_q <= 1'b0;
                txd_q  <= 1'b1;
            end else begin
                txd_q   <= shreg_q[0];
                shreg_q <= {1'b1, shreg_q[BYTE_W:1]};
                left_q  <= left_q - 1'b1;
            end
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign busy = busy_q;
    assign txd  = txd_q;

    // R3: a frame always opens with a low start bit
    assert_start_low_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !txd);

    // R4: the line rests high whenever no frame is being sent
    assert_idle_high_R4: assert property (@(posedge clk) disable iff (rst)
        !busy |-> txd);

    // R9: the latched period holds for the whole frame
    assert_period_held_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(bt_q));

endmodule

// File: rtl/ubt_rx.sv
module ubt_rx #(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [CNT_W-1:0]          bit_time,
    input  logic                      rxd,
    output logic                      valid,
    output logic [ubt_pkg::BYTE_W-1:0] data,
    output logic                      frame_err
);
    import ubt_pkg::*;

    localparam int IDX_W = $clog2(BYTE_W);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   line;
    logic                   prev_q;

    generate
        if (SYNC_STAGES == 1) begin : g_sync1
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '1;
                else     sync_q <= rxd;
            end
        end else begin : g_syncn
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '1;
                else     sync_q <= {sync_q[SYNC_STAGES-2:0], rxd};
            end
        end
    endgenerate

    assign line = sync_q[SYNC_STAGES-1];

    rx_state_e         st_q;
    logic [CNT_W-1:0]  bt_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [IDX_W-1:0]  idx_q;
    logic [BYTE_W-1:0] sr_q;
    rx_result_t        res_q;
    logic              valid_q;
    logic [CNT_W-1:0]  half;
    logic              full_end;
    logic              half_end;

    assign half     = {1'b0, bt_q[CNT_W-1:1]};
    assign full_end = (cnt_q == bt_q - 1'b1);
    assign half_end = (cnt_q == half - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= 1'b1;
            st_q    <= RX_IDLE;
            bt_q    <= '0;
            cnt_q   <= '0;
            idx_q   <= '0;
            sr_q    <= '0;
            res_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            prev_q          <= line;
            valid_q         <= 1'b0;
            res_q.frame_err <= 1'b0;
            case (st_q)
                RX_IDLE: begin
                    if (prev_q && !line) begin
                        st_q  <= RX_START;
                        bt_q  <= bit_time;
                        cnt_q <= '0;
                    end
                end
                RX_START: begin
                    if (half_end) begin
                        cnt_q <= '0;
                        idx_q <= '0;
                        st_q  <= line ? RX_IDLE : RX_DATA;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (full_end) begin
                        cnt_q <= '0;
                        sr_q  <= {line, sr_q[BYTE_W-1:1]};
                        if (idx_q == IDX_W'(BYTE_W - 1)) st_q <= RX_STOP;
                        else                             idx_q <= idx_q + 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (full_end) begin
                        cnt_q           <= '0;
                        valid_q         <= 1'b1;
                        res_q.data      <= sr_q;
                        res_q.frame_err <= !line;
                        st_q            <= RX_IDLE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: st_q <= RX_IDLE;
            endcase
        end
    end

    assign valid     = valid_q;
    assign data      = res_q.data;
    assign frame_err = res_q.frame_err;

    // R6: completion is reported as a single-cycle pulse
    assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);

    // R7: the error flag only ever accompanies a completion pulse
    assert_err_with_valid_R7: assert property (@(posedge clk) disable iff (rst)
        frame_err |-> valid);

    // R8: a rejected start leaves the receiver idle without reporting
    assert_false_start_R8: assert property (@(posedge clk) disable iff (rst)
        (st_q == RX_START && half_end && line) |=> (st_q == RX_IDLE && !valid));

endmodule

// File: rtl/ubt_uart.sv
module ubt_uart #(
    parameter int CNT_W       = 16,
    parameter int RESET_BT    = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [15:0]      cfg_wdata,
    output logic [15:0]      cfg_rdata,
    input  logic             tx_start,
    input  logic [7:0]       tx_data,
    output logic             tx_busy,
    output logic             txd,
    input  logic             rxd,
    output logic [7:0]       rx_data,
    output logic             rx_valid,
    output logic             rx_frame_err
);
    logic [CNT_W-1:0] bit_time;

    ubt_bitreg #(.CNT_W(CNT_W), .RESET_VAL(RESET_BT)) u_bitreg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata[CNT_W-1:0]),
        .rdata (bit_time)
    );

    assign cfg_rdata = 16'(bit_time);

    ubt_tx #(.CNT_W(CNT_W)) u_tx (
        .clk      (clk),
        .rst      (rst),
        .bit_time (bit_time),
        .start    (tx_start),
        .data     (tx_data),
        .busy     (tx_busy),
        .txd      (txd)
    );

    ubt_rx #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .bit_time  (bit_time),
        .rxd       (rxd),
        .valid     (rx_valid),
        .data      (rx_data),
        .frame_err (rx_frame_err)
    );

endmodule

// File: tb/ubt_uart_tb.sv
module ubt_uart_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [15:0] cfg_wdata;
    logic [15:0] cfg_rdata;
    logic        tx_start;
    logic [7:0]  tx_data;
    logic        tx_busy;
    logic        txd;
    logic        rxd;
    logic [7:0]  rx_data;
    logic        rx_valid;
    logic        rx_frame_err;

    int checks = 0;
    int errors = 0;

    int         rx_cnt = 0;
    logic [7:0] rx_last;
    logic       rx_last_err;

    always #5 clk = ~clk;

    ubt_uart u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .tx_start(tx_start), .tx_data(tx_data),
        .tx_busy(tx_busy), .txd(txd), .rxd(rxd), .rx_data(rx_data),
        .rx_valid(rx_valid), .rx_frame_err(rx_frame_err)
    );

    always @(negedge clk) begin
        if (rx_valid) begin
            rx_cnt      <= rx_cnt + 1;
            rx_last     <= rx_data;
            rx_last_err <= rx_frame_err;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [15:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // R3 R4 R5 R9: send one byte and check every bit at its middle
    task automatic tx_frame(input logic [7:0] b, input int bt,
                            input bit inj_start, input bit inj_wr);
        logic [9:0] frame;
        frame = {1'b1, b, 1'b0};
        @(negedge clk);
        tx_data = b; tx_start = 1'b1;
        @(negedge clk);
        tx_start = 1'b0;
        for (int k = 0; k < 10; k++) begin
            int w;
            w = bt / 2;
            if (inj_start && k == 3) begin
                tx_start = 1'b1; tx_data = ~b;
                @(negedge clk);
                tx_start = 1'b0; w--;
            end
            if (inj_wr && k == 5) begin
                cfg_we = 1'b1; cfg_wdata = 16'd40;
                @(negedge clk);
                cfg_we = 1'b0; w--;
            end
            repeat (w) @(negedge clk);
            chk($sformatf("R3 tx bit %0d", k), 32'(txd), 32'(frame[k]));
            chk("R4 busy in frame", 32'(tx_busy), 32'd1);
            repeat (bt - bt / 2) @(negedge clk);
        end
        chk("R4 busy low after frame", 32'(tx_busy), 32'd0);
        chk("R4 idle line high", 32'(txd), 32'd1);
        repeat (2) @(negedge clk);
        chk("R5 no second frame", 32'(tx_busy), 32'd0);
    endtask

    task automatic rx_send(input logic [7:0] b, input int bt, input logic stop);
        @(negedge clk);
        rxd = 1'b0;
        repeat (bt) @(negedge clk);
        for (int k = 0; k < 8; k++) begin
            rxd = b[k];
            repeat (bt) @(negedge clk);
        end
        rxd = stop;
        repeat (bt) @(negedge clk);
        rxd = 1'b1;
        repeat (bt) @(negedge clk);
    endtask

    task automatic rx_expect(input string req, input int cnt0,
                             input logic [7:0] b, input logic err);
        chk({req, " valid count"}, 32'(rx_cnt), 32'(cnt0 + 1));
        chk({req, " data"}, 32'(rx_last), 32'(b));
        chk({req, " frame error"}, 32'(rx_last_err), 32'(err));
    endtask

    task automatic test_reset();
        chk("R1 reset period", 32'(cfg_rdata), 32'd16);
        chk("R1 reset txd", 32'(txd), 32'd1);
        chk("R1 reset busy", 32'(tx_busy), 32'd0);
        chk("R1 reset valid", 32'(rx_valid), 32'd0);
    endtask

    task automatic test_register();
        cfg_write(16'd22);
        chk("R2 write 22", 32'(cfg_rdata), 32'd22);
        cfg_write(16'hFFFF);
        chk("R2 write FFFF", 32'(cfg_rdata), 32'hFFFE);
        cfg_write(16'd21);
        chk("R2 write 21", 32'(cfg_rdata), 32'd20);
    endtask

    task automatic test_tx_basic();
        tx_frame(8'hA5, 20, 1'b0, 1'b0);
        tx_frame(8'h3C, 20, 1'b1, 1'b0);
    endtask

    task automatic test_rx_basic();
        int c0;
        c0 = rx_cnt;
        rx_send(8'h5A, 20, 1'b1);
        rx_expect("R6 rx 5A", c0, 8'h5A, 1'b0);
        c0 = rx_cnt;
        rx_send(8'hC3, 20, 1'b0);
        rx_expect("R7 stop low", c0, 8'hC3, 1'b1);
        repeat (5) @(negedge clk);
        chk("R7 flag cleared", 32'(rx_frame_err), 32'd0);
    endtask

    task automatic test_false_start();
        int c0;
        c0 = rx_cnt;
        @(negedge clk);
        rxd = 1'b0;
        repeat (2) @(negedge clk);
        rxd = 1'b1;
        repeat (60) @(negedge clk);
        chk("R8 glitch ignored", 32'(rx_cnt), 32'(c0));
        rx_send(8'h17, 20, 1'b1);
        rx_expect("R8 next frame", c0, 8'h17, 1'b0);
    endtask

    task automatic test_short_period();
        int c0;
        cfg_write(16'd9);
        chk("R2 write 9", 32'(cfg_rdata), 32'd8);
        c0 = rx_cnt;
        rx_send(8'h00, 8, 1'b1);
        rx_expect("R6 rx 00", c0, 8'h00, 1'b0);
        c0 = rx_cnt;
        rx_send(8'hFF, 8, 1'b1);
        rx_expect("R6 rx FF", c0, 8'hFF, 1'b0);
        tx_frame(8'h81, 8, 1'b0, 1'b0);
    endtask

    task automatic test_concurrent();
        int c0;
        cfg_write(16'd20);
        c0 = rx_cnt;
        fork
            tx_frame(8'h96, 20, 1'b0, 1'b1);
            begin
                @(negedge clk);
                rx_send(8'h69, 20, 1'b1);
            end
        join
        rx_expect("R10 R9 concurrent rx", c0, 8'h69, 1'b0);
        chk("R9 register updated", 32'(cfg_rdata), 32'd40);
        cfg_write(16'd20);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; cfg_we = 1'b0; cfg_wdata = '0;
        tx_start = 1'b0; tx_data = '0; rxd = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_register();
        test_tx_basic();
        test_rx_basic();
        test_false_start();
        test_short_period();
        test_concurrent();
        repeat (5) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule